// File: doc/BRIEF.md
# Local Bus Cycle Controller

This block turns internal transfer requests of a 16-bit processor core into external bus cycles on a 24-bit physical address bus. A request carries a kind, an address, a size (byte or word), write data and a lock flag. The kind is one of memory read, memory write, I/O read, I/O write, code fetch, interrupt acknowledge or halt. The block drives the address and high-byte enable. It drives the active-low status pair, the memory/IO and code/interrupt qualifiers and the active-low lock strobe. On writes it drives the data bus. On reads it captures the data bus when the external active-low ready input ends the cycle.

Requests enter through a valid/ready handshake. The block can accept a request while it is idle, and on the last command clock of the running cycle, so cycles can run back to back. `req_ready` is the only back-pressure. The core holds `req_valid` and the request fields steady until the clock where both are high. The read response is a single-clock `rsp_valid` pulse with `rsp_rdata`. It has no ready of its own, because the core has already committed to the cycle when it issues the request.

A second bus master can take the bus with `hold`. The block finishes the cycle in progress and spends one clock with its address, byte enable, lock and data drivers off. It then raises `hlda` and keeps the bus released until `hold` falls. A hold request is not granted while a lock is in force.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: `req_ready` is high only in the idle state with no hold grant due, or in a command clock where `ready_n` is low and no hold grant is due. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low while `hlda` is high.
- R2: In the clock after a request is taken, `bus_s_n` shows the status code for exactly one clock, then returns to 2'b11 (idle). The codes are: 2'b01 for memory read, I/O read, code fetch and interrupt acknowledge; 2'b10 for memory and I/O writes; 2'b00 for halt. The request kind encoding is 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 code fetch, 5 interrupt acknowledge, 6 halt.
- R3: `bus_mio` is 1 for memory read, memory write, code fetch and halt, and 0 for I/O and interrupt acknowledge. `bus_cod_inta` is 1 for code fetch and for both I/O kinds, and 0 for memory data, interrupt acknowledge and halt.
- R4: After the status clock the cycle stays in its command state, with no limit, until `ready_n` is sampled low. The cycle then ends on that clock.
- R5: A word access drives `bus_bhe_n` = 0. A byte access at an even address drives `bus_bhe_n` = 1 (low lane D7-D0). A byte access at an odd address drives `bus_bhe_n` = 0 (high lane D15-D8). `bus_addr` carries the request address.
- R6: During I/O cycles, `bus_addr` bits 23 to 16 are driven 0.
- R7: `bus_data_oe` is high only during the status and command clocks of a write. A word write drives `req_wdata`. A byte write drives `req_wdata[7:0]` on both lanes.
- R8: For a read, code fetch or interrupt acknowledge, `bus_din` is sampled on the clock where `ready_n` ends the cycle. In the next clock `rsp_valid` is high for one clock with `rsp_rdata` holding the data. For a word this is all 16 bits. For a byte it is the selected lane zero-extended. Writes and halt give no response.
- R9: `bus_lock_n` goes low from the status clock of a locked cycle and stays low until the cycle after it ends. A locked cycle is one with `req_lock` = 1, or any interrupt acknowledge.
- R10: With `hold` high, the block completes the current cycle. It then spends one clock with `bus_ctl_oe` and `bus_data_oe` low and `hlda` low, and then raises `hlda`. It lowers `hlda` and drives the bus again in the clock after `hold` falls. The grant is deferred while a lock is in force.
- R11: `ready_n` has no effect outside the command state. In particular, while idle or while `hlda` is high it starts no cycle and gives no response.
- R12: A request taken on the final command clock of a cycle starts its status clock in the very next clock, with no idle clock between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this clock when valid is also high |
| req_kind | input | 3 | Cycle kind, encoding in R2 |
| req_addr | input | 24 | Physical or port address |
| req_wide | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data |
| req_lock | input | 1 | Lock this cycle and the next |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | 16 | Read data, lane-aligned |
| bus_addr | output | 24 | Address bus |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_ctl_oe | output | 1 | Drive enable for address, byte enable and lock |
| bus_dout | output | 16 | Data bus, outbound |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_din | input | 16 | Data bus, inbound |
| bus_s_n | output | 2 | Active-low status pair |
| bus_mio | output | 1 | Memory/IO qualifier |
| bus_cod_inta | output | 1 | Code/interrupt qualifier |
| bus_lock_n | output | 1 | Bus lock, active low |
| ready_n | input | 1 | Cycle end, active low |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
The bench uses the default sizes: a 24-bit address, a 16-bit data bus, a 16-bit I/O port space and a lock span of two cycles. With these, the zeroing of address bits 23 to 16 on I/O cycles shows up on the pins. Both byte lanes and the word case can be reached. The two-cycle lock can be stretched across an interrupt acknowledge and the following read while a hold request waits on it. Wait counts of zero to three command clocks cover the single-clock command and longer stretches.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [2:0] {
    K_MEM_RD = 3'd0,
    K_MEM_WR = 3'd1,
    K_IO_RD  = 3'd2,
    K_IO_WR  = 3'd3,
    K_CODE   = 3'd4,
    K_INTA   = 3'd5,
    K_HALT   = 3'd6
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT,
    ST_CMD,
    ST_FLT,
    ST_HLD
  } st_e;

  function automatic logic [1:0] status_code(kind_e k);
    case (k)
      K_MEM_RD, K_IO_RD, K_CODE, K_INTA: status_code = 2'b01;
      K_MEM_WR, K_IO_WR:                 status_code = 2'b10;
      K_HALT:                            status_code = 2'b00;
      default:                           status_code = 2'b11;
    endcase
  endfunction

  function automatic logic kind_writes(kind_e k);
    kind_writes = (k == K_MEM_WR) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_returns(kind_e k);
    kind_returns = (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_CODE) || (k == K_INTA);
  endfunction

  function automatic logic kind_mio(kind_e k);
    kind_mio = (k == K_MEM_RD) || (k == K_MEM_WR) || (k == K_CODE) || (k == K_HALT);
  endfunction

  function automatic logic kind_cod(kind_e k);
    kind_cod = (k == K_CODE) || (k == K_IO_RD) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_io(kind_e k);
    kind_io = (k == K_IO_RD) || (k == K_IO_WR);
  endfunction

endpackage

// File: rtl/lbus_lane_map.sv
module lbus_lane_map #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int IO_ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic              is_io,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_out,
  output logic              bhe_n,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata_sel
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    addr_out = addr;
    if (is_io) addr_out[ADDR_W-1:IO_ADDR_W] = '0;
    bhe_n = !(wide || addr[0]);
    dout  = wide ? wdata : {2{wdata[LANE_W-1:0]}};
    if (wide)
      rdata_sel = din;
    else if (addr[0])
      rdata_sel = {{LANE_W{1'b0}}, din[DATA_W-1:LANE_W]};
    else
      rdata_sel = {{LANE_W{1'b0}}, din[LANE_W-1:0]};
  end
endmodule

// File: rtl/lbus_lock_track.sv
module lbus_lock_track #(
  parameter int LOCK_SPAN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic new_locked,
  input  logic cycle_end,
  output logic lock_active,
  output logic lock_free_after
);
  localparam int CW = $clog2(LOCK_SPAN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (accept && new_locked)
      left_q <= CW'(LOCK_SPAN);
    else if (cycle_end && left_q != '0)
      left_q <= left_q - CW'(1);
  end

  assign lock_active     = (left_q != '0);
  assign lock_free_after = (left_q <= CW'(1));
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hold,
  input  logic ready_n,
  input  logic lock_active,
  input  logic lock_free_after,
  output st_e  state,
  output logic req_ready,
  output logic accept,
  output logic cycle_end
);
  st_e  state_d;
  logic grant_idle, grant_end;

  always_comb begin
    cycle_end  = (state == ST_CMD) && !ready_n;
    grant_idle = hold && !lock_active;
    grant_end  = hold && lock_free_after;
    req_ready  = ((state == ST_IDLE) && !grant_idle) || (cycle_end && !grant_end);
    accept     = req_valid && req_ready;
    state_d    = state;
    case (state)
      ST_IDLE: if (grant_idle) state_d = ST_FLT;
               else if (accept) state_d = ST_STAT;
      ST_STAT: state_d = ST_CMD;
      ST_CMD:  if (cycle_end) begin
                 if (grant_end)   state_d = ST_FLT;
                 else if (accept) state_d = ST_STAT;
                 else             state_d = ST_IDLE;
               end
      ST_FLT:  state_d = ST_HLD;
      ST_HLD:  if (!hold) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
  import lbus_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int IO_ADDR_W = 16,
  parameter int LOCK_SPAN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_lock,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_ctl_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic [1:0]        bus_s_n,
  output logic              bus_mio,
  output logic              bus_cod_inta,
  output logic              bus_lock_n,
  input  logic              ready_n,
  input  logic              hold,
  output logic              hlda
);
  st_e  state;
  logic accept, cycle_end, lock_active, lock_free_after;
  logic new_locked;

  kind_e             cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wide;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] rdata_sel;

  assign new_locked = req_lock || (kind_e'(req_kind) == K_INTA);

  lbus_seq seq_i (
    .clk, .rst_n, .req_valid, .hold, .ready_n,
    .lock_active, .lock_free_after,
    .state, .req_ready, .accept, .cycle_end
  );

  lbus_lock_track #(.LOCK_SPAN(LOCK_SPAN)) lock_i (
    .clk, .rst_n, .accept, .new_locked, .cycle_end,
    .lock_active, .lock_free_after
  );

  lbus_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_ADDR_W(IO_ADDR_W)) lane_i (
    .addr(cur_addr), .wide(cur_wide), .is_io(kind_io(cur_kind)),
    .wdata(cur_wdata), .din(bus_din),
    .addr_out(bus_addr), .bhe_n(bus_bhe_n), .dout(bus_dout), .rdata_sel(rdata_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind  <= K_MEM_RD;
      cur_addr  <= '0;
      cur_wide  <= 1'b0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_kind  <= kind_e'(req_kind);
      cur_addr  <= req_addr;
      cur_wide  <= req_wide;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cycle_end && kind_returns(cur_kind);
      if (cycle_end && kind_returns(cur_kind)) rsp_rdata <= rdata_sel;
    end
  end

  always_comb begin
    bus_ctl_oe   = (state != ST_FLT) && (state != ST_HLD);
    bus_data_oe  = ((state == ST_STAT) || (state == ST_CMD)) && kind_writes(cur_kind);
    bus_s_n      = (state == ST_STAT) ? status_code(cur_kind) : 2'b11;
    bus_mio      = kind_mio(cur_kind);
    bus_cod_inta = kind_cod(cur_kind);
    bus_lock_n   = !lock_active;
    hlda         = (state == ST_HLD);
  end
endmodule

// File: rtl/lbus_cycle_ctrl_chk.sv
module lbus_cycle_ctrl_chk #(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ctl_oe,
  input logic              bus_data_oe,
  input logic [1:0]        bus_s_n,
  input logic              bus_mio,
  input logic              bus_cod_inta,
  input logic              ready_n,
  input logic              hlda
);
  // R10
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_ctl_oe && !bus_data_oe));

  // R10
  float_before_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(!bus_ctl_oe));

  // R2
  status_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_s_n != 2'b11) |=> (bus_s_n == 2'b11));

  // R6
  io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_s_n != 2'b11 && !bus_mio && bus_cod_inta) |-> (bus_addr[ADDR_W-1:IO_ADDR_W] == '0));

  // R8
  rsp_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!ready_n));

  // R1
  no_take_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !req_ready);

  // R7
  data_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && bus_s_n != 2'b11) |-> (bus_s_n == 2'b10));
endmodule

bind lbus_cycle_ctrl lbus_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_addr(bus_addr), .bus_ctl_oe(bus_ctl_oe), .bus_data_oe(bus_data_oe),
  .bus_s_n(bus_s_n), .bus_mio(bus_mio), .bus_cod_inta(bus_cod_inta),
  .ready_n(ready_n), .hlda(hlda)
);

// File: tb/lbus_cycle_ctrl_tb.sv
module lbus_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [23:0] req_addr = '0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_lock = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic        bus_bhe_n, bus_ctl_oe, bus_data_oe, bus_mio, bus_cod_inta, bus_lock_n, hlda;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic [1:0]  bus_s_n;
  logic        ready_n = 1'b1;
  logic        hold = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lbus_cycle_ctrl dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_addr, .req_wide,
    .req_wdata, .req_lock, .rsp_valid, .rsp_rdata, .bus_addr, .bus_bhe_n,
    .bus_ctl_oe, .bus_dout, .bus_data_oe, .bus_din, .bus_s_n, .bus_mio,
    .bus_cod_inta, .bus_lock_n, .ready_n, .hold, .hlda
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [23:0] addr;
    logic        wide;
    logic [15:0] wdata;
    logic [15:0] din;
    logic [3:0]  waits;
    logic [1:0]  s;
    logic        mio;
    logic        cod;
    logic        bhe;
    logic [23:0] eaddr;
    logic        doe;
    logic [15:0] dout;
    logic        rsp;
    logic [15:0] rdata;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 24'h012344, 1'b1, 16'h0000, 16'hBEEF, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0, 24'h012344, 1'b0, 16'h0000, 1'b1, 16'hBEEF},
    '{3'd1, 24'h00A001, 1'b0, 16'h0055, 16'h0000, 4'd2, 2'b10, 1'b1, 1'b0, 1'b0, 24'h00A001, 1'b1, 16'h5555, 1'b0, 16'h0000},
    '{3'd2, 24'hFF0060, 1'b0, 16'h0000, 16'h1234, 4'd1, 2'b01, 1'b0, 1'b1, 1'b1, 24'h000060, 1'b0, 16'h0000, 1'b1, 16'h0034},
    '{3'd3, 24'h7F0080, 1'b1, 16'hCAFE, 16'h0000, 4'd0, 2'b10, 1'b0, 1'b1, 1'b0, 24'h000080, 1'b1, 16'hCAFE, 1'b0, 16'h0000},
    '{3'd4, 24'h0F0000, 1'b1, 16'h0000, 16'h9090, 4'd3, 2'b01, 1'b1, 1'b1, 1'b0, 24'h0F0000, 1'b0, 16'h0000, 1'b1, 16'h9090},
    '{3'd0, 24'h000101, 1'b0, 16'h0000, 16'hAB12, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0, 24'h000101, 1'b0, 16'h0000, 1'b1, 16'h00AB},
    '{3'd6, 24'h000002, 1'b1, 16'h0000, 16'h0000, 4'd0, 2'b00, 1'b1, 1'b0, 1'b0, 24'h000002, 1'b0, 16'h0000, 1'b0, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_req(input logic [2:0] k, input logic [23:0] a, input logic w,
                         input logic [15:0] d, input logic lk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wide = w; req_wdata = d; req_lock = lk;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    put_req(v.kind, v.addr, v.wide, v.wdata, 1'b0);
    #1 check("R1 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R2 status code", bus_s_n, v.s);
    check("R3 mio", bus_mio, v.mio);
    check("R3 cod_inta", bus_cod_inta, v.cod);
    check("R5 bhe_n", bus_bhe_n, v.bhe);
    check("R5 R6 address", bus_addr, v.eaddr);
    check("R7 data_oe", bus_data_oe, v.doe);
    if (v.doe) check("R7 write data", bus_dout, v.dout);
    for (int w = 0; w < int'(v.waits); w++) begin
      @(negedge clk);
      ready_n = 1'b1;
      #1;
      check("R2 status idle in command", bus_s_n, 2'b11);
      check("R4 waiting not ready", req_ready, 0);
      check("R4 no early response", rsp_valid, 0);
    end
    @(negedge clk);
    ready_n = 1'b0; bus_din = v.din;
    @(negedge clk);
    ready_n = 1'b1; bus_din = 16'h0;
    #1;
    check("R8 response pulse", rsp_valid, v.rsp);
    if (v.rsp) check("R8 read data", rsp_rdata, v.rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R2 reset status idle", bus_s_n, 2'b11);
    check("R10 reset hlda", hlda, 0);
    check("R10 reset ctl_oe", bus_ctl_oe, 1);
    check("R7 reset data_oe", bus_data_oe, 0);
    check("R9 reset lock", bus_lock_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: ready_n low in idle starts nothing
    @(negedge clk);
    ready_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 idle status", bus_s_n, 2'b11);
    check("R11 idle no response", rsp_valid, 0);
    ready_n = 1'b1;

    // R12: back-to-back cycles
    @(negedge clk);
    put_req(3'd0, 24'h000010, 1'b1, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    ready_n = 1'b0; bus_din = 16'h4321;
    put_req(3'd1, 24'h000020, 1'b1, 16'h1111, 1'b0);
    #1 check("R12 taken at cycle end", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; ready_n = 1'b1;
    #1;
    check("R12 status without gap", bus_s_n, 2'b10);
    check("R12 next address", bus_addr, 24'h000020);
    check("R12 R8 prior read data", rsp_rdata, 16'h4321);
    check("R12 R8 prior pulse", rsp_valid, 1);
    @(negedge clk);
    ready_n = 1'b0;
    @(negedge clk);
    ready_n = 1'b1;

    // R10 R11 R1: hold arriving during a cycle
    @(negedge clk);
    put_req(3'd0, 24'h000030, 1'b1, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    hold = 1'b1;
    #1;
    check("R10 cycle kept under hold", bus_ctl_oe, 1);
    check("R10 no early grant", hlda, 0);
    @(negedge clk);
    ready_n = 1'b0; bus_din = 16'h7777;
    @(negedge clk);
    ready_n = 1'b1;
    put_req(3'd1, 24'h000050, 1'b1, 16'h2222, 1'b0);
    #1;
    check("R10 float clock oe", bus_ctl_oe, 0);
    check("R10 float clock hlda", hlda, 0);
    check("R8 data before grant", rsp_rdata, 16'h7777);
    check("R1 not ready while floating", req_ready, 0);
    @(negedge clk);
    ready_n = 1'b0;
    #1;
    check("R10 hlda raised", hlda, 1);
    check("R10 data floated", bus_data_oe, 0);
    check("R1 not ready in hold", req_ready, 0);
    @(negedge clk);
    #1;
    check("R11 ready ignored in hold", hlda, 1);
    check("R11 no response in hold", rsp_valid, 0);
    check("R11 no status in hold", bus_s_n, 2'b11);
    hold = 1'b0; ready_n = 1'b1;
    @(negedge clk);
    #1;
    check("R10 hlda dropped", hlda, 0);
    check("R10 bus driven again", bus_ctl_oe, 1);
    check("R1 ready after hold", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R1 pending request started", bus_s_n, 2'b10);
    @(negedge clk);
    ready_n = 1'b0;
    @(negedge clk);
    ready_n = 1'b1;

    // R9 R10: interrupt acknowledge locks itself and the next cycle; hold waits
    @(negedge clk);
    put_req(3'd5, 24'h000000, 1'b1, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R9 lock on inta", bus_lock_n, 0);
    check("R3 inta mio", bus_mio, 0);
    check("R3 inta cod", bus_cod_inta, 0);
    hold = 1'b1;
    @(negedge clk);
    ready_n = 1'b0; bus_din = 16'h0008;
    @(negedge clk);
    ready_n = 1'b1;
    #1;
    check("R10 grant deferred by lock", hlda, 0);
    check("R10 bus kept under lock", bus_ctl_oe, 1);
    check("R9 lock held between cycles", bus_lock_n, 0);
    check("R8 inta vector", rsp_rdata, 16'h0008);
    check("R1 ready under lock", req_ready, 1);
    put_req(3'd0, 24'h000040, 1'b1, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R9 lock on following cycle", bus_lock_n, 0);
    @(negedge clk);
    ready_n = 1'b0;
    @(negedge clk);
    ready_n = 1'b1;
    #1;
    check("R10 float after lock ends", bus_ctl_oe, 0);
    check("R10 float clock no hlda", hlda, 0);
    @(negedge clk);
    #1 check("R10 grant after lock", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    #1;
    check("R9 lock released", bus_lock_n, 1);
    check("R10 released hlda", hlda, 0);

    // R9: explicit lock flag on a write
    @(negedge clk);
    put_req(3'd1, 24'h000060, 1'b1, 16'h3333, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R9 lock from flag", bus_lock_n, 0);
    @(negedge clk);
    ready_n = 1'b0;
    @(negedge clk);
    ready_n = 1'b1;
    put_req(3'd0, 24'h000062, 1'b1, 16'h0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    ready_n = 1'b0;
    @(negedge clk);
    ready_n = 1'b1;
    #1 check("R9 lock ends after second cycle", bus_lock_n, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule